// File: doc/BRIEF.md
# Recursive Field Noise Reduction Filter

This block is the per-pixel arithmetic of a recursive temporal noise reducer for 12-bit video samples arriving one per clock. For every incoming sample it also receives the co-sited sample of one field earlier. That earlier sample is read back from a field memory, which lies outside this block. The block blends the two and returns a filtered sample, which the system writes back into the same memory. The loop therefore smooths noise over successive fields.

The sample is handled as two lanes: an 8-bit luminance value in bits [11:4] and a 4-bit chroma nibble in bits [3:0]. A 2-bit strength class sets how hard the filter smooths. The blend is adaptive: the blend gain depends on the size of the field-to-field difference, and any difference larger than the class threshold is treated as motion and passed through unfiltered. In the 4:2:2 mode only the luminance lane is filtered, and the chroma nibble travels through a delay of the same length. While blanking is asserted, samples pass through untouched. Class, mode and blanking are all captured together with each sample.

Top module: `tnr_field_filter`

## Requirements
- R1: Every sample, together with its valid flag, appears at the outputs exactly two clock cycles after it is presented. `out_valid` repeats `in_valid` with that same delay, and the datapath processes every sample whatever its valid flag.
- R2: With class 0, the output equals the input sample, delayed by two cycles, for both lanes.
- R3: While `blank` is high, the output equals the input sample, delayed by two cycles, regardless of class and mode.
- R4: For classes 1 to 3, each filtered lane outputs prev + floor((k·(cur − prev) + 4) / 8). Here cur is the current lane value, prev is the fed-back lane value, and k is a gain in eighths.
- R5: For a lane of width w and class c, the motion threshold is T = 2^(c+w−5). If |cur − prev| > T then k = 8, so the output is cur. If |cur − prev| ≤ T/2 (integer halving) then k = 8 >> c. Otherwise k = 2·(8 >> c).
- R6: With `mode_422` low, the chroma nibble in bits [3:0] is filtered as a separate 4-bit lane under R4 and R5. The luminance lane uses bits [11:4] with w = 8.
- R7: With `mode_422` high, bits [3:0] of the output equal bits [3:0] of the input two cycles earlier, while bits [11:4] are still filtered.
- R8: Each output lane value lies between the lane's cur and prev values inclusive, and is saturated to the range 0 to 2^w − 1.
- R9: While reset is asserted, and until the first sample has passed through, `out_valid` is 0 and `out_sample` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the incoming sample as valid |
| in_sample | input | 12 | Current sample: luminance in [11:4], chroma nibble in [3:0] |
| fb_sample | input | 12 | Same pixel from one field earlier, read from the field memory |
| blank | input | 1 | Blanking interval: pass the sample through unfiltered |
| mode_422 | input | 1 | 1: filter luminance only and delay chroma; 0: filter both lanes |
| nr_class | input | 2 | Strength class: 0 off, 1 to 3 increasingly strong |
| out_valid | output | 1 | Valid flag aligned with out_sample |
| out_sample | output | 12 | Filtered sample, written back to the field memory |

## Verification
The state inside this block is a two-stage pipeline per lane. A captured gain, a bypass flag or a held sample that goes wrong shows up in `out_sample` two cycles after the input that caused it. A swapped gain table entry or a wrong threshold edge only shows for particular difference magnitudes, so the sweep steps the luminance difference across every threshold of every class. It also runs all chroma nibble pairs under each class, mode and blanking combination. A closed-loop section feeds the model's own earlier outputs back as the field sample. An error there would compound over the fields, but it is still caught on the first sample where it appears.

// File: rtl/tnr_pkg.sv
package tnr_pkg;

   localparam int CLASS_W = 2;

   typedef logic [CLASS_W-1:0] tnr_class_t;

   // motion threshold for a lane of width w under class cls (cls >= 1)
   function automatic int unsigned motion_thr(input int unsigned cls, input int unsigned w);
      return 32'd1 << (cls + w - 32'd5);
   endfunction

   // blend gain in units of 1/2**kfrac, chosen by class and difference size
   function automatic int unsigned class_gain(input int unsigned cls, input int unsigned ad,
                                              input int unsigned w, input int unsigned kfrac);
      int unsigned kmax;
      int unsigned thr;
      int unsigned base;
      kmax = 32'd1 << kfrac;
      if (cls == 0) return kmax;
      thr  = motion_thr(cls, w);
      base = kmax >> cls;
      if (ad > thr) return kmax;
      if (ad <= (thr >> 1)) return base;
      return base << 1;
   endfunction

endpackage

// File: rtl/tnr_gain_stage.sv
module tnr_gain_stage #(
   parameter int W     = 8,
   parameter int KFRAC = 3,
   localparam int KW   = KFRAC + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [W-1:0]          cur,
   input  logic [W-1:0]          prev,
   input  tnr_pkg::tnr_class_t   cls,
   input  logic                  bypass,
   output logic [W-1:0]          cur_q,
   output logic [W-1:0]          prev_q,
   output logic [KW-1:0]         k_q,
   output logic                  byp_q
);
   localparam int unsigned KMAX = 32'd1 << KFRAC;

   initial begin
      if (W < 4) $error("tnr_gain_stage: lane width must be at least 4");
      if (KFRAC < 3) $error("tnr_gain_stage: gain fraction must be at least 3 bits");
   end

   logic [W-1:0]  ad;
   logic [KW-1:0] k_d;

   always_comb begin
      ad  = (cur >= prev) ? (cur - prev) : (prev - cur);
      k_d = KW'(tnr_pkg::class_gain(32'(cls), 32'(ad), W, KFRAC));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         prev_q <= '0;
         k_q    <= '0;
         byp_q  <= 1'b1;
      end else begin
         cur_q  <= cur;
         prev_q <= prev;
         k_q    <= k_d;
         byp_q  <= bypass;
      end
   end

   AST_OPEN_ON_MOTION: assert property (@(posedge clk) disable iff (!rst_n)
      ((cls != '0) && (32'(ad) > tnr_pkg::motion_thr(32'(cls), W))) |=> (k_q == KW'(KMAX))); // R5

endmodule

// File: rtl/tnr_blend_stage.sv
module tnr_blend_stage #(
   parameter int W     = 8,
   parameter int KFRAC = 3,
   localparam int KW   = KFRAC + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  cur_q,
   input  logic [W-1:0]  prev_q,
   input  logic [KW-1:0] k_q,
   input  logic          byp_q,
   output logic [W-1:0]  res_q
);
   localparam int DW = W + 1;
   localparam int PW = DW + KW + 1;
   localparam logic signed [PW-1:0] HALF_S = PW'(1 << (KFRAC - 1));
   localparam logic signed [PW-1:0] MAXV_S = PW'((1 << W) - 1);

   logic signed [DW-1:0] diff;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] step;
   logic signed [PW-1:0] sum;
   logic [W-1:0]         sat;
   logic [W-1:0]         lo;
   logic [W-1:0]         hi;

   always_comb begin
      diff = $signed({1'b0, cur_q}) - $signed({1'b0, prev_q});
      prod = $signed({{(PW-DW){diff[DW-1]}}, diff}) * $signed({{(PW-KW){1'b0}}, k_q});
      step = (prod + HALF_S) >>> KFRAC;
      sum  = step + $signed({{(PW-W){1'b0}}, prev_q});
      if (sum[PW-1])         sat = '0;
      else if (sum > MAXV_S) sat = '1;
      else                   sat = sum[W-1:0];
      lo = (cur_q < prev_q) ? cur_q : prev_q;
      hi = (cur_q < prev_q) ? prev_q : cur_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= byp_q ? cur_q : sat;
   end

   AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      byp_q |=> (res_q == $past(cur_q))); // R3

   AST_OUT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      !byp_q |=> ((res_q >= $past(lo)) && (res_q <= $past(hi)))); // R8

endmodule

// File: rtl/tnr_field_filter.sv
module tnr_field_filter #(
   parameter int DATA_W = 12,
   parameter int LUMA_W = 8,
   parameter int KFRAC  = 3,
   localparam int CHROMA_W = DATA_W - LUMA_W,
   localparam int N_LANES  = 2,
   localparam int KW       = KFRAC + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [DATA_W-1:0]          in_sample,
   input  logic [DATA_W-1:0]          fb_sample,
   input  logic                       blank,
   input  logic                       mode_422,
   input  logic [tnr_pkg::CLASS_W-1:0] nr_class,
   output logic                       out_valid,
   output logic [DATA_W-1:0]          out_sample
);
   initial begin
      if (LUMA_W < 4)   $error("tnr_field_filter: luminance lane too narrow");
      if (CHROMA_W < 4) $error("tnr_field_filter: chroma lane too narrow");
      if (KFRAC < 3)    $error("tnr_field_filter: gain needs at least 3 fraction bits");
   end

   logic class_off;
   logic vld_s1;
   logic vld_s2;

   assign class_off = (nr_class == '0);

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam int LW = (g == 0) ? LUMA_W : CHROMA_W;
      localparam int LO = (g == 0) ? CHROMA_W : 0;

      logic          byp;
      logic [LW-1:0] cur_q;
      logic [LW-1:0] prev_q;
      logic [KW-1:0] k_q;
      logic          byp_q;
      logic [LW-1:0] res_q;

      if (g == 0) begin : g_luma_ctl
         assign byp = blank | class_off;
      end else begin : g_chroma_ctl
         assign byp = blank | class_off | mode_422;
      end

      tnr_gain_stage #(.W(LW), .KFRAC(KFRAC)) u_gain (
         .clk    (clk),
         .rst_n  (rst_n),
         .cur    (in_sample[LO +: LW]),
         .prev   (fb_sample[LO +: LW]),
         .cls    (nr_class),
         .bypass (byp),
         .cur_q  (cur_q),
         .prev_q (prev_q),
         .k_q    (k_q),
         .byp_q  (byp_q)
      );

      tnr_blend_stage #(.W(LW), .KFRAC(KFRAC)) u_blend (
         .clk    (clk),
         .rst_n  (rst_n),
         .cur_q  (cur_q),
         .prev_q (prev_q),
         .k_q    (k_q),
         .byp_q  (byp_q),
         .res_q  (res_q)
      );

      assign out_sample[LO +: LW] = res_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_s1 <= 1'b0;
         vld_s2 <= 1'b0;
      end else begin
         vld_s1 <= in_valid;
         vld_s2 <= vld_s1;
      end
   end

   assign out_valid = vld_s2;

   AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2)) |-> (out_valid == $past(in_valid, 2))); // R1

endmodule

// File: tb/tnr_field_filter_tb.sv
module tnr_field_filter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [11:0] in_sample = '0;
   logic [11:0] fb_sample = '0;
   logic        blank = 1'b0;
   logic        mode_422 = 1'b0;
   logic [1:0]  nr_class = '0;
   logic        out_valid;
   logic [11:0] out_sample;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // expected pipeline: index 0 = driven one negedge ago, 1 = two ago
   logic [11:0] e_smp [2];
   logic        e_vld [2];
   string       e_tl  [2];
   string       e_tc  [2];
   int          e_lo  [2];
   int          e_hi  [2];

   logic [11:0] fmem [8];

   always #4 clk = ~clk;

   tnr_field_filter u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sample  (in_sample),
      .fb_sample  (fb_sample),
      .blank      (blank),
      .mode_422   (mode_422),
      .nr_class   (nr_class),
      .out_valid  (out_valid),
      .out_sample (out_sample)
   );

   function automatic int lane_model(input int cu, input int pr, input int cls, input int w);
      int thr, ad, k, r;
      thr = 1 << (cls + w - 5);
      ad  = (cu > pr) ? cu - pr : pr - cu;
      if (ad > thr)             k = 8;
      else if (ad <= thr / 2)   k = 8 >> cls;
      else                      k = 2 * (8 >> cls);
      r = pr + ((k * (cu - pr) + 4) >>> 3);
      if (r < 0) r = 0;
      if (r > (1 << w) - 1) r = (1 << w) - 1;
      return r;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_out();
      check("R1 valid", int'(out_valid), int'(e_vld[1]));
      check({e_tl[1], " luma"}, int'(out_sample[11:4]), int'(e_smp[1][11:4]));
      check({e_tc[1], " chroma"}, int'(out_sample[3:0]), int'(e_smp[1][3:0]));
      check("R8 luma range", int'(out_sample[11:4]) >= e_lo[1] && int'(out_sample[11:4]) <= e_hi[1], 1);
   endtask

   task automatic apply(input logic [11:0] c, input logic [11:0] p, input int cls,
                        input logic md, input logic bl, input logic vl, output logic [11:0] res);
      int cl, pl, cc, pc, el, ec, thr, ad;
      @(negedge clk);
      check_out();
      e_smp[1] = e_smp[0]; e_vld[1] = e_vld[0]; e_tl[1] = e_tl[0];
      e_tc[1]  = e_tc[0];  e_lo[1]  = e_lo[0];  e_hi[1] = e_hi[0];
      in_sample = c; fb_sample = p; nr_class = 2'(cls);
      mode_422 = md; blank = bl; in_valid = vl;
      cl = int'(c[11:4]); pl = int'(p[11:4]);
      cc = int'(c[3:0]);  pc = int'(p[3:0]);
      if (bl || cls == 0) el = cl; else el = lane_model(cl, pl, cls, 8);
      if (bl || cls == 0 || md) ec = cc; else ec = lane_model(cc, pc, cls, 4);
      thr = (cls == 0) ? 0 : (1 << (cls + 3));
      ad  = (cl > pl) ? cl - pl : pl - cl;
      e_tl[0] = bl ? "R3" : (cls == 0) ? "R2" : (ad > thr) ? "R5" : "R4";
      e_tc[0] = bl ? "R3" : (cls == 0) ? "R2" : md ? "R7" : "R6";
      e_smp[0] = {8'(el), 4'(ec)};
      e_vld[0] = vl;
      e_lo[0]  = (bl || cls == 0) ? cl : ((cl < pl) ? cl : pl);
      e_hi[0]  = (bl || cls == 0) ? cl : ((cl < pl) ? pl : cl);
      res = e_smp[0];
   endtask

   initial begin
      logic [11:0] r;
      for (int j = 0; j < 2; j++) begin
         e_smp[j] = '0; e_vld[j] = 1'b0; e_tl[j] = "R9"; e_tc[j] = "R9";
         e_lo[j] = 0; e_hi[j] = 0;
      end
      for (int j = 0; j < 8; j++) fmem[j] = 12'h800;
      repeat (3) @(negedge clk);
      check("R9 reset valid", int'(out_valid), 0);
      check("R9 reset sample", int'(out_sample), 0);
      rst_n = 1'b1;

      // sweep: every class, mode and blanking, luma difference across all thresholds
      for (int cls = 0; cls < 4; cls++) begin
         for (int md = 0; md < 2; md++) begin
            for (int bl = 0; bl < 2; bl++) begin
               for (int i = 0; i < 512; i++) begin
                  int pl, cl, d;
                  pl = (i * 37 + cls * 11) & 255;
                  d  = (i % 181) - 90;
                  cl = pl + d;
                  if (cl < 0) cl = 0;
                  if (cl > 255) cl = 255;
                  apply({8'(cl), 4'(i & 15)}, {8'(pl), 4'((i >> 4) & 15)}, cls,
                        1'(md), 1'(bl), 1'((i % 7) != 3), r);
               end
            end
         end
      end

      // closed loop: field memory modelled as an 8-sample delay of expected outputs
      for (int cls = 1; cls < 4; cls++) begin
         for (int i = 0; i < 400; i++) begin
            int noise;
            noise = ((i * 29 + cls * 7) % 13) - 6;
            apply({8'(128 + noise + ((i / 64) * 3)), 4'(8 + (noise >>> 1))}, fmem[i % 8],
                  cls, 1'(i >= 200), 1'b0, 1'b1, r);
            fmem[i % 8] = r;
         end
      end

      // drain the pipeline
      repeat (2) apply(12'h000, 12'h000, 0, 1'b0, 1'b0, 1'b0, r);
      @(negedge clk);
      check_out();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule